// File: doc/BRIEF.md
# Card Stream-Write Data-Line Controller

This block drives the single data line of a serial memory card during an open-ended stream write. It sits on the host side. After the command path has seen the end of the card's answer to a sequential-write command, it pulses `resp_end_i`. The block then counts a configurable start delay and shifts bytes out from a valid/ready byte source, most significant bit first. The bytes follow each other with no gaps. No block length is used and no checksum is added.

The stream ends at a byte boundary. This happens either when the host raises `stop_i` or when the byte source has nothing to give. The block then sends one end bit of value 1 and releases the line. It watches the line for the card's start bit and follows the low busy level that comes after it. When the card releases the line, a one-cycle `done_o` pulse reports that programming has finished. A busy period longer than a programmable limit is ended early and flagged on `timeout_o`. Erase uses the same watcher: an `erase_start_i` pulse skips the transmit phases and goes straight to waiting for busy.

Top module: `card_stream_writer`

## Requirements
- R1: While reset is active and right after it, `dat_oe_o`, `data_ready_o`, `busy_o`, `done_o` and `timeout_o` are all low.
- R2: If `resp_end_i` is high in cycle c, the first stream bit is driven with `dat_oe_o` high in cycle c+N. N is `nwr_cfg_i`, and values below 2 count as 2.
- R3: Each byte goes out most significant bit first, one bit per clock, and consecutive bytes follow with no gap. `data_ready_o` is high for one cycle per byte: in the last delay cycle, and then in the last bit cycle of each byte. A byte is taken when `data_valid_i` and `data_ready_o` are both high.
- R4: A `stop_i` pulse during the delay or the stream lets the current byte finish. After that, exactly one bit of value 1 is driven, and then `dat_oe_o` falls. No checksum bits are sent.
- R5: If `data_valid_i` is low at a byte boundary, the stream ends in the same way as with a stop, after the bytes already taken.
- R6: Take the first cycle with `dat_oe_o` low after the end bit as t=0. If `dat_i` is first low at t=d with d<8, and stays low for L cycles, then `busy_o` is high for min(L, LIMIT) cycles starting at t=d+1. `done_o` then pulses for one cycle. LIMIT is `busy_limit_i`.
- R7: If `dat_i` stays high for t=0..7, `done_o` pulses at t=8 and `busy_o` never rises.
- R8: `timeout_o` rises together with `done_o` exactly when L > LIMIT. It stays high until the next operation starts, and it is low in the first cycle of that operation.
- R9: An `erase_start_i` pulse in cycle c starts the busy watch with t=0 at cycle c+1. `dat_oe_o` stays low and no byte is requested.
- R10: `done_o` lasts one cycle, and the block accepts a new command in the next cycle. A `stop_i` pulse while idle has no effect on the following operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_end_i | input | 1 | Pulse: card response to sequential-write command has ended |
| erase_start_i | input | 1 | Pulse: start watching for erase busy |
| nwr_cfg_i | input | NWR_W | Start delay in clocks |
| busy_limit_i | input | LIMIT_W | Maximum busy length in clocks |
| data_i | input | DATA_W | Byte to be streamed |
| data_valid_i | input | 1 | `data_i` holds a byte |
| data_ready_o | output | 1 | Byte is taken at this clock edge if valid |
| stop_i | input | 1 | Request to end the stream |
| dat_o | output | 1 | Data line output value |
| dat_oe_o | output | 1 | Data line output enable |
| dat_i | input | 1 | Data line input value |
| busy_o | output | 1 | Card is signalling busy |
| done_o | output | 1 | One-cycle pulse: operation complete |
| timeout_o | output | 1 | Last busy period exceeded the limit |

## Verification
The bench sweeps every start delay from 0 to 5 against every start-bit offset from 0 to 9 and every busy length from 1 to 7, with a limit of 5. Stop-ended streams and underrun-ended streams alternate, and the number of bytes changes from run to run. The delay sweep shows whether values below 2 are clamped and whether the delay is off by one. Stops placed at every bit position of the final byte show whether the stop takes effect at the byte boundary and not at once. Start-bit offsets on both sides of 8 separate the busy path from the no-busy path. Busy lengths below, equal to and above the limit locate the exact timeout edge. Erase runs, and a stop pulse while idle, check the paths that skip transmission.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_NWR,
    ST_STREAM,
    ST_END_BIT,
    ST_TURN,
    ST_BUSY_WAIT,
    ST_DONE
  } csw_state_e;

  localparam int unsigned MIN_NWR = 2;
endpackage

// File: rtl/csw_phase_counter.sv
`timescale 1ns/1ps
// Cycle counter shared by all timed phases; cleared on every state change.
module csw_phase_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/csw_byte_shifter.sv
`timescale 1ns/1ps
// Parallel-load shift register, MSB first, with bit position tracking.
module csw_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          msb,
  output logic          last
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] pos_q, pos_d;

  always_comb begin
    sh_d  = sh_q;
    pos_d = pos_q;
    if (load) begin
      sh_d  = din;
      pos_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      pos_d = pos_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
    end
  end

  assign msb  = sh_q[DW-1];
  assign last = (pos_q == BW'(DW-1));
endmodule

// File: rtl/card_stream_writer.sv
`timescale 1ns/1ps
module card_stream_writer #(
  parameter int DATA_W  = 8,
  parameter int NWR_W   = 4,
  parameter int LIMIT_W = 16,
  parameter int WINDOW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resp_end_i,
  input  logic               erase_start_i,
  input  logic [NWR_W-1:0]   nwr_cfg_i,
  input  logic [LIMIT_W-1:0] busy_limit_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               data_valid_i,
  output logic               data_ready_o,
  input  logic               stop_i,
  output logic               dat_o,
  output logic               dat_oe_o,
  input  logic               dat_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  import csw_pkg::*;

  localparam int CNT_W = LIMIT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  csw_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             phase_clr, cnt_en;
  logic             stop_q, stop_d, err_q, err_d;
  logic             sh_msb, sh_last, sh_load, sh_shift;
  logic [NWR_W-1:0] nwr_eff;
  logic             wait_last, boundary, stop_any, win_last, busy_over, to_set;
  logic [CNT_W:0]   cnt_p1;

  assign phase_clr = (state_d != state_q);
  assign cnt_en    = (state_q != ST_IDLE);

  csw_phase_counter #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .clr(phase_clr), .en(cnt_en), .cnt(cnt)
  );

  csw_byte_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(sh_load), .shift(sh_shift),
    .din(data_i), .msb(sh_msb), .last(sh_last)
  );

  assign nwr_eff   = (nwr_cfg_i < NWR_W'(MIN_NWR)) ? NWR_W'(MIN_NWR) : nwr_cfg_i;
  assign wait_last = (state_q == ST_WAIT_NWR) &&
                     (cnt == (CNT_W'(nwr_eff) - CNT_W'(MIN_NWR)));
  assign boundary  = wait_last || ((state_q == ST_STREAM) && sh_last);
  assign stop_any  = stop_q || stop_i;
  assign data_ready_o = boundary && !stop_any;
  assign sh_load   = data_ready_o && data_valid_i;
  assign sh_shift  = (state_q == ST_STREAM) && !sh_last;
  assign win_last  = (cnt == CNT_W'(WINDOW - 1));
  assign cnt_p1    = {1'b0, cnt} + (CNT_W+1)'(1);
  assign busy_over = (cnt_p1 >= {1'b0, busy_limit_i});
  assign to_set    = (state_q == ST_BUSY_WAIT) && !dat_i && busy_over;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (resp_end_i)         state_d = ST_WAIT_NWR;
        else if (erase_start_i) state_d = ST_TURN;
      end
      ST_WAIT_NWR: if (wait_last) state_d = sh_load ? ST_STREAM : ST_END_BIT;
      ST_STREAM:   if (sh_last)   state_d = sh_load ? ST_STREAM : ST_END_BIT;
      ST_END_BIT:  state_d = ST_TURN;
      ST_TURN: begin
        if (!dat_i)        state_d = ST_BUSY_WAIT;
        else if (win_last) state_d = ST_DONE;
      end
      ST_BUSY_WAIT: if (dat_i || busy_over) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    stop_d = stop_q;
    if (state_q == ST_IDLE) stop_d = 1'b0;
    else if (stop_i && (state_q == ST_WAIT_NWR || state_q == ST_STREAM)) stop_d = 1'b1;
    err_d = err_q;
    if (state_q == ST_IDLE && state_d != ST_IDLE) err_d = 1'b0;
    else if (to_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
      err_q   <= err_d;
    end
  end

  assign dat_oe_o  = (state_q == ST_STREAM) || (state_q == ST_END_BIT);
  assign dat_o     = (state_q == ST_STREAM) ? sh_msb : 1'b1;
  assign busy_o    = (state_q == ST_BUSY_WAIT);
  assign done_o    = (state_q == ST_DONE);
  assign timeout_o = err_q;
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker (
  input logic clk,
  input logic rst_n,
  input logic dat_oe_o,
  input logic dat_o,
  input logic dat_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic data_ready_o
);
  p_released_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !dat_oe_o);
  p_end_bit_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe_o) |-> $past(dat_o));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_busy_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(dat_i));
  p_release_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dat_i) |=> (done_o && !busy_o));
  p_ready_only_sending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> (!busy_o && !done_o));
  p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> done_o);
endmodule

bind card_stream_writer csw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dat_oe_o(dat_oe_o), .dat_o(dat_o), .dat_i(dat_i),
  .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
  .data_ready_o(data_ready_o)
);

// File: tb/card_stream_writer_test.sv
`timescale 1ns/1ps
module card_stream_writer_test;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst_n, resp_end, erase_start, valid, stop, dat_i;
  logic [3:0]  nwr;
  logic [15:0] limit;
  logic [7:0]  data;
  logic        ready, dat_o, dat_oe, busy, done, tmo;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  card_stream_writer uut (
    .clk(clk), .rst_n(rst_n), .resp_end_i(resp_end), .erase_start_i(erase_start),
    .nwr_cfg_i(nwr), .busy_limit_i(limit), .data_i(data), .data_valid_i(valid),
    .data_ready_o(ready), .stop_i(stop), .dat_o(dat_o), .dat_oe_o(dat_oe),
    .dat_i(dat_i), .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  // one operation: stream (or erase) followed by the card busy model
  task automatic run_op(input int ncfg, input int k, input bit use_stop,
                        input int d, input int l, input bit erase, input int seed);
    int neff, j, first_oe, nbits, rel, busy_cnt, done_j, idx, bad_bits, mn;
    bit took, oe_late, to_seen;
    logic got[0:127];
    neff = (ncfg < 2) ? 2 : ncfg;
    first_oe = -1; nbits = 0; rel = -1; busy_cnt = 0; done_j = -1;
    idx = 0; took = 0; oe_late = 0; to_seen = 0; bad_bits = 0;
    nwr = 4'(ncfg); valid = !erase; data = byte_of(seed, 0); dat_i = 1'b1;
    @(negedge clk);
    resp_end = !erase; erase_start = erase;
    @(negedge clk);
    resp_end = 1'b0; erase_start = 1'b0;
    if (erase) rel = 1;
    j = 1;
    while (done_j < 0 && j < 200) begin
      if (j == 1) chk(tmo == 1'b0, "R8 timeout cleared at start", tmo, 0);
      if (took) begin
        idx++;
        data = byte_of(seed, idx);
        if (!use_stop && idx == k) valid = 1'b0;
      end
      if (dat_oe) begin
        if (rel >= 0) oe_late = 1;
        if (first_oe < 0) first_oe = j;
        if (nbits < 128) got[nbits] = dat_o;
        nbits++;
      end else if (first_oe >= 0 && rel < 0) rel = j;
      stop = (use_stop && dat_oe && (nbits - 1 == 8 * (k - 1) + (l % 8))) ? 1'b1 : 1'b0;
      if (rel >= 0) dat_i = ((j - rel) >= d && (j - rel) < d + l) ? 1'b0 : 1'b1;
      #1;
      took = ready && valid;
      if (erase && ready) oe_late = 1;
      if (busy) busy_cnt++;
      if (done) done_j = j;
      if (done) to_seen = tmo;
      j++;
      if (done_j < 0) @(negedge clk);
    end
    stop = 1'b0; dat_i = 1'b1; valid = 1'b0;
    mn = (l < LIM) ? l : LIM;
    if (!erase) begin
      chk(first_oe == neff, "R2 first bit cycle", first_oe, neff);
      chk(nbits == 8 * k + 1, use_stop ? "R4 bit count after stop" : "R5 bit count after underrun",
          nbits, 8 * k + 1);
      if (nbits == 8 * k + 1) begin
        for (int b = 0; b < 8 * k; b++)
          if (got[b] !== byte_of(seed, b / 8)[7 - (b % 8)]) bad_bits++;
        chk(bad_bits == 0, "R3 MSB-first byte stream", bad_bits, 0);
        chk(got[8 * k] === 1'b1, "R4 end bit value", int'(got[8 * k]), 1);
      end
    end
    chk(!oe_late, erase ? "R9 erase drives nothing" : "R4 line stays released", oe_late, 0);
    if (d < 8) begin
      chk(busy_cnt == mn, "R6 busy length", busy_cnt, mn);
      chk(done_j == rel + d + 1 + mn, "R6 done cycle", done_j, rel + d + 1 + mn);
      chk(to_seen == (l > LIM), "R8 timeout flag", to_seen, int'(l > LIM));
    end else begin
      chk(busy_cnt == 0, "R7 no busy", busy_cnt, 0);
      chk(done_j == rel + 8, "R7 done after window", done_j, rel + 8);
    end
    @(negedge clk);
    chk(!done && !busy, "R10 single done pulse, back to idle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int run;
    rst_n = 1'b0; resp_end = 1'b0; erase_start = 1'b0; valid = 1'b0; stop = 1'b0;
    dat_i = 1'b1; nwr = 4'd2; limit = 16'(LIM); data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!dat_oe && !ready && !busy && !done && !tmo, "R1 outputs during reset", dat_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!dat_oe && !ready && !busy && !done && !tmo, "R1 outputs after reset", dat_oe, 0);

    // stop while idle must not shorten the next stream
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    #1;
    chk(!dat_oe && !done, "R10 idle stop ignored", dat_oe, 0);
    run_op(3, 2, 1'b0, 2, 3, 1'b0, 99);

    run = 0;
    for (int n = 0; n < 6; n++)
      for (int d = 0; d < 10; d++)
        for (int l = 1; l < 8; l++) begin
          run_op(n, 1 + (d + l) % 3, 1'((n + d + l) % 2), d, l, 1'b0, run);
          run++;
        end

    // erase sweeps (R9)
    for (int d = 0; d < 10; d += 3)
      for (int l = 1; l < 8; l += 2)
        run_op(0, 1, 1'b0, d, l, 1'b1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule